// File: doc/BRIEF.md
# Paged Indirect Register Access Master

This block reaches the wide internal registers of a switch, which are not visible on the management bus directly. A host hands it one request at a time: an 8-bit page, an 8-bit register offset, a width code, a direction and up to 64 bits of write data. The block turns that request into a fixed sequence of 16-bit register transactions on a clause-22 management bus. Every transaction goes to one PHY address, 30 by default, which the switch reserves for this tunnel. The transactions leave through a simple request/acknowledge port to an existing MDIO master. The serial framing belongs to that master.

Each access uses three kinds of register. A page-select register takes the page number. An address/opcode register takes the offset and a read or write command. Four 16-bit data windows, 0x18 to 0x1B, hold the value, with 0x18 carrying the least significant word. After the command is issued, the block polls the opcode register until the switch clears the command bits. The number of polls is bounded. Between polls the block waits a gap, given in clock cycles. When the sequence ends, the block returns the assembled read data, or it flags an error on a timeout, on a bus error or on an unsupported width.

Top module: `paged_reg_seq`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done` and `mdio_req` are low until a request is accepted.
- R2: Every management transaction carries the PHY address given by the `PHY_ADDR` parameter (30 by default).
- R3: A write first loads the data windows in ascending order from 0x18, least significant word first. The word count is 1 for width codes 0 (8 bits) and 1 (16 bits), 2 for code 2 (32 bits), 3 for code 3 (48 bits) and 4 for code 4 (64 bits). An 8-bit write sends its upper byte as zero. The page write, the opcode write and the poll follow.
- R4: The page step writes register 0x10 with the page in bits 15:8, bits 7:1 zero and bit 0 set.
- R5: The command step writes register 0x11 with the offset in bits 15:8, bits 7:2 zero and the opcode in bits 1:0: 01 for a write, 10 for a read.
- R6: After the command, the block reads register 0x11 until bits 1:0 read as zero. It makes at most `POLL_TRIES` reads (5 by default), with at least `GAP_CYCLES` cycles between two reads. If all of them return a nonzero opcode, the request ends with an error.
- R7: A read issues the page write, the command write and the poll first, and only then reads the data windows in ascending order. `rdata` holds the words least significant first, with unused upper bits zero. For width code 0, only the low byte of window 0x18 is kept.
- R8: An acknowledge that carries `mdio_err` ends the request at once. No further transaction is issued, and `done` pulses with `err` set.
- R9: Width codes 5 to 7 end the request with `done` and `err` one cycle after acceptance, and no transaction is issued.
- R10: `busy` is high from the cycle after acceptance until the request ends. `done` is a one-cycle pulse during which `busy` is already low. While `busy` is high, `req_valid` and the request fields are ignored.
- R11: Once `mdio_req` rises, it and the transaction fields hold steady until `mdio_ack`. `mdio_req` then drops for at least one cycle before the next transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_page | input | 8 | Register page |
| req_offset | input | 8 | Register offset inside the page |
| req_width | input | 3 | Width code: 0=8, 1=16, 2=32, 3=48, 4=64 bits |
| req_wdata | input | 64 | Write data, least significant bits used for narrow widths |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Error status of the last request, valid with `done` |
| rdata | output | 64 | Read result of the last request |
| mdio_req | output | 1 | Transaction request to the MDIO master |
| mdio_write | output | 1 | 1 = register write, 0 = register read |
| mdio_phy | output | 5 | PHY address of the transaction |
| mdio_reg | output | 5 | Register number of the transaction |
| mdio_wdata | output | 16 | Write value of the transaction |
| mdio_ack | input | 1 | One-cycle completion from the MDIO master |
| mdio_err | input | 1 | Transaction failed, valid with `mdio_ack` |
| mdio_rdata | input | 16 | Read value, valid with `mdio_ack` |

## Verification
The assertions rely on two assumptions about the MDIO master. It raises `mdio_ack` only while `mdio_req` is high, and the acknowledge lasts exactly one cycle. They also assume that `GAP_CYCLES` is at least one. The bench's responder keeps to this: it waits 1 to 3 cycles after each request rises, pulses the acknowledge once, and checks that the request fields did not move in between. On the host side, the bench wiggles the request fields and `req_valid` only while `busy` is high, or while the block is idle between requests.

// File: rtl/prs_pkg.sv
// Shared constants, types and helpers for the paged register sequencer.
// Assumes a clause-22 bus with 5-bit register numbers and 16-bit data.
package prs_pkg;
    localparam int WORD_W     = 16;
    localparam int NUM_WIN    = 4;
    localparam int DATA_W     = WORD_W * NUM_WIN;
    localparam int REG_ADDR_W = 5;
    localparam int PAGE_W     = 8;
    localparam int OFFS_W     = 8;
    localparam int WSEL_W     = $clog2(NUM_WIN);

    localparam logic [REG_ADDR_W-1:0] REG_PAGE_SEL = 5'h10;
    localparam logic [REG_ADDR_W-1:0] REG_CMD      = 5'h11;
    localparam logic [REG_ADDR_W-1:0] REG_WIN_BASE = 5'h18;

    localparam logic [1:0] CMD_WR = 2'b01;
    localparam logic [1:0] CMD_RD = 2'b10;

    localparam logic [2:0] WCODE_8  = 3'd0;
    localparam logic [2:0] WCODE_16 = 3'd1;
    localparam logic [2:0] WCODE_64 = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WWIN,
        ST_PAGE,
        ST_CMD,
        ST_POLL,
        ST_GAP,
        ST_RWIN
    } seq_state_e;

    // Number of 16-bit windows a width code occupies.
    function automatic logic [2:0] words_for(input logic [2:0] code);
        logic [2:0] n;
        case (code)
            WCODE_8, WCODE_16: n = 3'd1;
            default:           n = code;
        endcase
        return n;
    endfunction
endpackage

// File: rtl/prs_gap_timer.sv
// Wait counter between completion polls.
// Assumes GAP_CYCLES >= 1. A start pulse arms it, and expired stays high
// in the cycle GAP_CYCLES cycles after the start. It is one-shot until
// the next start.
module prs_gap_timer #(
    parameter int GAP_CYCLES = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);
    localparam int CNT_W = $clog2(GAP_CYCLES + 1);

    logic [CNT_W-1:0] cnt;
    logic             run;

    // Load on start, count down while running, stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (start) begin
            cnt <= CNT_W'(GAP_CYCLES - 1);
            run <= 1'b1;
        end else if (run) begin
            if (cnt == '0) run <= 1'b0;
            else           cnt <= cnt - 1'b1;
        end
    end

    assign expired = run && (cnt == '0);

    // R6: the loaded count never exceeds the configured gap.
    p_gap_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (int'(cnt) < GAP_CYCLES));
endmodule

// File: rtl/prs_word_buf.sv
// Data staging for one request.
// Holds the write value, presents it to the bus as 16-bit windows (upper
// byte zeroed for 8-bit), and gathers read windows into a wide result.
// A load clears the read buffer and latches the width code.
module prs_word_buf
    import prs_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [DATA_W-1:0]   wdata_in,
    input  logic [2:0]          width_in,
    input  logic [WSEL_W-1:0]   sel,
    input  logic                cap,
    input  logic [WORD_W-1:0]   cap_word,
    output logic [WORD_W-1:0]   win_word,
    output logic [DATA_W-1:0]   rdata
);
    logic [WORD_W-1:0] wq [NUM_WIN];
    logic [WORD_W-1:0] rq [NUM_WIN];
    logic [2:0]        wcode;
    logic [WORD_W-1:0] wsel_word;

    // Latch the width of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)    wcode <= '0;
        else if (load) wcode <= width_in;
    end

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        // Write staging word g, latched at acceptance.
        always_ff @(posedge clk) begin
            if (!rst_n)    wq[g] <= '0;
            else if (load) wq[g] <= wdata_in[g*WORD_W +: WORD_W];
        end
        // Read word g, cleared at acceptance and filled by its window read.
        always_ff @(posedge clk) begin
            if (!rst_n)                                   rq[g] <= '0;
            else if (load)                                rq[g] <= '0;
            else if (cap && (sel == WSEL_W'(g)))          rq[g] <= cap_word;
        end
        assign rdata[g*WORD_W +: WORD_W] =
            (g == 0 && wcode == WCODE_8) ? {8'h00, rq[g][7:0]} :
            (wcode == WCODE_8)           ? '0 : rq[g];
    end

    // Select the outgoing write word and mask it for byte width.
    always_comb begin
        wsel_word = wq[sel];
        win_word  = (wcode == WCODE_8) ? {8'h00, wsel_word[7:0]} : wsel_word;
    end
endmodule

// File: rtl/paged_reg_seq.sv
// Paged indirect register access master.
// Runs one host request at a time as a series of management-bus
// transactions: data windows (writes only), page select, command, a
// bounded completion poll, then data windows (reads only).
// Assumes the MDIO master raises mdio_ack for one cycle, only while
// mdio_req is high, and that GAP_CYCLES >= 1 and POLL_TRIES >= 2.
module paged_reg_seq
    import prs_pkg::*;
#(
    parameter int PHY_ADDR   = 30,
    parameter int POLL_TRIES = 5,
    parameter int GAP_CYCLES = 10000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [PAGE_W-1:0]      req_page,
    input  logic [OFFS_W-1:0]      req_offset,
    input  logic [2:0]             req_width,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   busy,
    output logic                   done,
    output logic                   err,
    output logic [DATA_W-1:0]      rdata,
    output logic                   mdio_req,
    output logic                   mdio_write,
    output logic [4:0]             mdio_phy,
    output logic [REG_ADDR_W-1:0]  mdio_reg,
    output logic [WORD_W-1:0]      mdio_wdata,
    input  logic                   mdio_ack,
    input  logic                   mdio_err,
    input  logic [WORD_W-1:0]      mdio_rdata
);
    localparam int TRY_W = $clog2(POLL_TRIES + 1);

    seq_state_e          st;
    logic                req_q;
    logic [WSEL_W-1:0]   idx;
    logic [TRY_W-1:0]    tries;
    logic                is_wr;
    logic [PAGE_W-1:0]   page_q;
    logic [OFFS_W-1:0]   offs_q;
    logic [2:0]          nwords;
    logic                done_q;
    logic                err_q;

    logic                accept;
    logic                width_ok;
    logic                bus_state;
    logic                step_ack;
    logic                step_ok;
    logic                last_word;
    logic                poll_clear;
    logic                last_try;
    logic                gap_start;
    logic                gap_done;
    logic [WORD_W-1:0]   win_word;

    assign accept     = (st == ST_IDLE) && req_valid;
    assign width_ok   = (req_width <= WCODE_64);
    assign bus_state  = (st == ST_WWIN) || (st == ST_PAGE) || (st == ST_CMD) ||
                        (st == ST_POLL) || (st == ST_RWIN);
    assign step_ack   = req_q && mdio_ack;
    assign step_ok    = step_ack && !mdio_err;
    assign last_word  = ({1'b0, idx} == (nwords - 3'd1));
    assign poll_clear = (mdio_rdata[1:0] == 2'b00);
    assign last_try   = (tries == TRY_W'(POLL_TRIES - 1));
    assign gap_start  = (st == ST_POLL) && step_ok && !poll_clear && !last_try;

    prs_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (gap_start),
        .expired (gap_done)
    );

    prs_word_buf u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .wdata_in (req_wdata),
        .width_in (req_width),
        .sel      (idx),
        .cap      ((st == ST_RWIN) && step_ok),
        .cap_word (mdio_rdata),
        .win_word (win_word),
        .rdata    (rdata)
    );

    // Sequence state, bus request handshake and result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            req_q  <= 1'b0;
            idx    <= '0;
            tries  <= '0;
            is_wr  <= 1'b0;
            page_q <= '0;
            offs_q <= '0;
            nwords <= 3'd1;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (step_ack)                req_q <= 1'b0;
            else if (bus_state && !req_q) req_q <= 1'b1;

            if (step_ack && mdio_err) begin
                st     <= ST_IDLE;
                done_q <= 1'b1;
                err_q  <= 1'b1;
            end else begin
                case (st)
                    ST_IDLE: if (accept) begin
                        is_wr  <= req_write;
                        page_q <= req_page;
                        offs_q <= req_offset;
                        nwords <= words_for(req_width);
                        idx    <= '0;
                        tries  <= '0;
                        err_q  <= 1'b0;
                        if (!width_ok) begin
                            done_q <= 1'b1;
                            err_q  <= 1'b1;
                        end else begin
                            st <= req_write ? ST_WWIN : ST_PAGE;
                        end
                    end
                    ST_WWIN: if (step_ok) begin
                        if (last_word) st <= ST_PAGE;
                        else           idx <= idx + 1'b1;
                    end
                    ST_PAGE: if (step_ok) st <= ST_CMD;
                    ST_CMD: if (step_ok) begin
                        st    <= ST_POLL;
                        tries <= '0;
                    end
                    ST_POLL: if (step_ok) begin
                        if (poll_clear) begin
                            if (is_wr) begin
                                st     <= ST_IDLE;
                                done_q <= 1'b1;
                            end else begin
                                st  <= ST_RWIN;
                                idx <= '0;
                            end
                        end else if (last_try) begin
                            st     <= ST_IDLE;
                            done_q <= 1'b1;
                            err_q  <= 1'b1;
                        end else begin
                            tries <= tries + 1'b1;
                            st    <= ST_GAP;
                        end
                    end
                    ST_GAP: if (gap_done) st <= ST_POLL;
                    ST_RWIN: if (step_ok) begin
                        if (last_word) begin
                            st     <= ST_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    // Transaction fields for the current step.
    always_comb begin
        mdio_write = 1'b0;
        mdio_reg   = REG_CMD;
        mdio_wdata = '0;
        case (st)
            ST_WWIN: begin
                mdio_write = 1'b1;
                mdio_reg   = REG_WIN_BASE + REG_ADDR_W'(idx);
                mdio_wdata = win_word;
            end
            ST_PAGE: begin
                mdio_write = 1'b1;
                mdio_reg   = REG_PAGE_SEL;
                mdio_wdata = {page_q, 7'b0, 1'b1};
            end
            ST_CMD: begin
                mdio_write = 1'b1;
                mdio_reg   = REG_CMD;
                mdio_wdata = {offs_q, 6'b0, (is_wr ? CMD_WR : CMD_RD)};
            end
            ST_RWIN: mdio_reg = REG_WIN_BASE + REG_ADDR_W'(idx);
            default: ;
        endcase
    end

    assign mdio_req = req_q;
    assign mdio_phy = 5'(PHY_ADDR);
    assign busy     = (st != ST_IDLE);
    assign done     = done_q;
    assign err      = err_q;

    // R1 / R10: no bus traffic while idle.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_req);
    // R10: done is a single-cycle pulse seen only once busy has dropped.
    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R11: a pending transaction keeps its fields until acknowledged.
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_req && !mdio_ack) |=> (mdio_req && $stable(mdio_reg) &&
                                     $stable(mdio_wdata) && $stable(mdio_write)));
    // R11: the request drops after each acknowledge.
    p_req_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_req && mdio_ack) |=> !mdio_req);
    // R8: an errored acknowledge ends the request in the next cycle.
    p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_req && mdio_ack && mdio_err) |=> (done && err && !busy));
    // R6: the poll counter stays inside the configured bound.
    p_tries_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(tries) < POLL_TRIES);
    // R6: no transaction while waiting out the poll gap.
    p_gap_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_GAP) |-> !mdio_req);
endmodule

// File: tb/paged_reg_seq_bench.sv
module paged_reg_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int GAP        = 6;
    localparam int TRIES      = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_page = '0, req_offset = '0;
    logic [2:0]  req_width = '0;
    logic [63:0] req_wdata = '0;
    logic        busy, done, err;
    logic [63:0] rdata;
    logic        mdio_req, mdio_write;
    logic [4:0]  mdio_phy, mdio_reg;
    logic [15:0] mdio_wdata;
    logic        mdio_ack = 1'b0, mdio_err = 1'b0;
    logic [15:0] mdio_rdata = '0;

    paged_reg_seq #(.PHY_ADDR(30), .POLL_TRIES(TRIES), .GAP_CYCLES(GAP)) u_paged_reg_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_page(req_page), .req_offset(req_offset), .req_width(req_width),
        .req_wdata(req_wdata), .busy(busy), .done(done), .err(err), .rdata(rdata),
        .mdio_req(mdio_req), .mdio_write(mdio_write), .mdio_phy(mdio_phy),
        .mdio_reg(mdio_reg), .mdio_wdata(mdio_wdata), .mdio_ack(mdio_ack),
        .mdio_err(mdio_err), .mdio_rdata(mdio_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_bad = 0, cyc = 0;
    // Responder model state
    int tx_n, err_step, busy_cfg, poll_left, poll_n, last_poll, min_gap;
    int win_wr_cnt, win_rd_cnt, win_before_cmd, page_idx, cmd_idx;
    logic [15:0] page_val, cmd_val;
    logic [15:0] win [4];
    logic [15:0] win_snap [4];
    logic [7:0]  offs_m;
    logic [1:0]  cmd_m;
    bit bad_phy, bad_hold, bad_order, rd_early;
    logic        got_err;
    logic [63:0] got_rdata;

    initial forever begin @(posedge clk); cyc++; end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input logic [7:0] pg, input logic [7:0] of, input int i);
        return {pg ^ 8'(i * 37 + 5), of + 8'(i * 17 + 3)};
    endfunction

    function automatic int nwords(input int w);
        return (w <= 1) ? 1 : w;
    endfunction

    task automatic model_clear();
        tx_n = 0; poll_n = 0; last_poll = 0; min_gap = 1000000;
        win_wr_cnt = 0; win_rd_cnt = 0; win_before_cmd = -1;
        page_idx = -1; cmd_idx = -1; page_val = '0; cmd_val = '0;
        bad_phy = 0; bad_hold = 0; bad_order = 0; rd_early = 0;
        poll_left = 0; offs_m = '0; cmd_m = '0;
        for (int i = 0; i < 4; i++) begin win[i] = 16'hDEAD; win_snap[i] = 16'hDEAD; end
    endtask

    // Plays the switch: page/command/window registers and a busy countdown.
    task automatic serve(input logic wr, input logic [4:0] rg, input logic [15:0] wd, input logic [4:0] ph);
        if (ph != 5'd30) bad_phy = 1;
        mdio_rdata = '0;
        if (tx_n == err_step) begin mdio_err = 1'b1; tx_n++; return; end
        tx_n++;
        if (wr) begin
            if (rg == 5'h10) begin page_val = wd; page_idx = tx_n - 1; end
            else if (rg == 5'h11) begin
                cmd_val = wd; cmd_idx = tx_n - 1; offs_m = wd[15:8]; cmd_m = wd[1:0];
                poll_left = busy_cfg; win_before_cmd = win_wr_cnt;
                for (int i = 0; i < 4; i++) begin
                    if (wd[1:0] == 2'b10) win[i] = pat(page_val[15:8], wd[15:8], i);
                    win_snap[i] = win[i];
                end
            end else if (rg >= 5'h18 && rg <= 5'h1B) begin
                if (int'(rg[1:0]) != win_wr_cnt || cmd_idx >= 0) bad_order = 1;
                win[rg[1:0]] = wd; win_wr_cnt++;
            end
        end else begin
            if (rg == 5'h11) begin
                if (poll_n > 0 && (cyc - last_poll) < min_gap) min_gap = cyc - last_poll;
                last_poll = cyc; poll_n++;
                mdio_rdata = {offs_m, 6'b0, (poll_left > 0) ? cmd_m : 2'b00};
                if (poll_left > 0) poll_left--;
            end else if (rg >= 5'h18 && rg <= 5'h1B) begin
                if (cmd_idx < 0 || poll_n == 0 || poll_left > 0) rd_early = 1;
                if (int'(rg[1:0]) != win_rd_cnt) bad_order = 1;
                mdio_rdata = win[rg[1:0]]; win_rd_cnt++;
            end
        end
    endtask

    // MDIO master stand-in with a 1..3 cycle latency.
    initial forever begin
        @(negedge clk);
        mdio_ack = 1'b0; mdio_err = 1'b0;
        if (mdio_req) begin
            automatic logic       w0 = mdio_write;
            automatic logic [4:0] r0 = mdio_reg;
            automatic logic [15:0] d0 = mdio_wdata;
            automatic int lat = tx_n % 3;
            repeat (lat) begin
                @(negedge clk);
                if (!mdio_req || mdio_write !== w0 || mdio_reg !== r0 || mdio_wdata !== d0) bad_hold = 1;
            end
            serve(w0, r0, d0, mdio_phy);
            mdio_ack = 1'b1;
        end
    end

    task automatic do_req(input logic wr, input logic [7:0] pg, input logic [7:0] of,
                          input logic [2:0] w, input logic [63:0] d);
        int guard;
        model_clear();
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_page = pg; req_offset = of;
        req_width = w; req_wdata = d;
        @(negedge clk);
        if (!done) begin
            chk("R10 busy after accept", busy, 1'b1);
            req_write = ~wr; req_page = ~pg; req_offset = ~of; req_width = 3'd2; req_wdata = ~d;
            @(negedge clk);
            @(negedge clk);
        end
        req_valid = 1'b0;
        guard = 0;
        while (!done && guard < 4000) begin @(negedge clk); guard++; end
        if (guard >= 4000) chk("R10 request completes", 1'b0, 1'b1);
        chk("R10 busy low during done", busy, 1'b0);
        got_err = err; got_rdata = rdata;
        @(negedge clk);
        chk("R10 done one cycle", done, 1'b0);
    endtask

    task automatic run_case(input logic wr, input logic [7:0] pg, input logic [7:0] of,
                            input int w, input logic [63:0] d, input int bz);
        int n, polls, expn;
        bit tmo;
        logic [63:0] ewin, awin, erd;
        n = nwords(w); tmo = (bz >= TRIES); polls = tmo ? TRIES : bz + 1;
        busy_cfg = bz; err_step = -1;
        do_req(wr, pg, of, 3'(w), d);
        expn = 2 + polls + ((wr || !tmo) ? n : 0);
        chk("R6 error flag vs timeout", got_err, tmo);
        chk("R3 R7 transaction count", 64'(tx_n), 64'(expn));
        chk("R2 phy address 30", bad_phy, 1'b0);
        chk("R11 fields held until ack", bad_hold, 1'b0);
        chk("R4 page register value", page_val, {pg, 8'h01});
        chk("R5 command register value", cmd_val, {of, 6'b0, wr ? 2'b01 : 2'b10});
        chk("R6 poll count", 64'(poll_n), 64'(polls));
        if (polls > 1) chk("R6 gap between polls", (min_gap >= GAP), 1'b1);
        chk("R3 R7 window order", bad_order, 1'b0);
        if (wr) begin
            ewin = '0; awin = '0;
            for (int i = 0; i < n; i++) begin
                ewin[16*i +: 16] = d[16*i +: 16];
                awin[16*i +: 16] = win_snap[i];
            end
            if (w == 0) ewin[15:8] = 8'h00;
            chk("R3 windows before page", 64'(page_idx), 64'(n));
            chk("R3 window words", awin, ewin);
        end else begin
            chk("R7 page first", 64'(page_idx), 64'd0);
            chk("R7 no window read before poll clears", rd_early, 1'b0);
            if (!tmo) begin
                erd = '0;
                for (int i = 0; i < n; i++) erd[16*i +: 16] = pat(pg, of, i);
                if (w == 0) erd = {56'b0, erd[7:0]};
                chk("R7 read data", got_rdata, erd);
            end
        end
    endtask

    task automatic run_abort(input logic wr, input int w, input int k);
        int seen;
        busy_cfg = 0;
        err_step = k;
        do_req(wr, 8'h3C, 8'h44, 3'(w), 64'h0123_4567_89AB_CDEF);
        seen = tx_n;
        repeat (6) @(negedge clk);
        chk("R8 error flag on bus error", got_err, 1'b1);
        chk("R8 stops at failing step", 64'(seen), 64'(k + 1));
        chk("R8 no traffic after abort", 64'(tx_n), 64'(k + 1));
        err_step = -1;
    endtask

    initial begin
        err_step = -1; busy_cfg = 0;
        model_clear();
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", busy, 1'b0);
        chk("R1 done in reset", done, 1'b0);
        chk("R1 mdio_req in reset", mdio_req, 1'b0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 idle after reset", {busy, done, mdio_req}, 3'b000);

        // Sweep widths, directions and addresses.
        for (int w = 0; w <= 4; w++)
            for (int dir = 0; dir < 2; dir++)
                for (int a = 0; a < 2; a++)
                    run_case(dir[0], 8'(8'h31 + a * 8'h4E), 8'(w * 8'h13 + a * 8'h80),
                             w, 64'hFEDC_BA98_7654_3210 ^ 64'(a * 64'h1111_0000_2222_0303),
                             (w + a) % 3);

        // Poll bound sweep, both directions.
        for (int bz = 0; bz <= 6; bz++) begin
            run_case(1'b0, 8'h02, 8'h88, 2, 64'h0, bz);
            run_case(1'b1, 8'h00, 8'h0E, 3, 64'h0000_AAAA_5555_C3C3, bz);
        end

        // Bus error at every step.
        for (int k = 0; k < 7; k++) run_abort(1'b1, 4, k);
        for (int k = 0; k < 6; k++) run_abort(1'b0, 3, k);

        // Unsupported width codes.
        for (int w = 5; w <= 7; w++) begin
            busy_cfg = 0; err_step = -1;
            do_req(1'b0, 8'h10, 8'h20, 3'(w), 64'h0);
            repeat (4) @(negedge clk);
            chk("R9 error on bad width", got_err, 1'b1);
            chk("R9 no transactions on bad width", 64'(tx_n), 64'd0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        wait (cyc >= 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule